// File: doc/BRIEF.md
# CAN Controller Disable/Enable Sequencer

This block sequences a CAN controller into and out of its disabled, power-saving state. Software drives a single disable bit. When the bit is set, the sequencer waits a fixed number of cycles and then raises two status flags together: a low-power flag and a not-ready flag. In the same cycle it drops the clock-enable requests for the protocol engine and for the host-side interface. When the bit is cleared, the sequencer first asks for both clocks to come back. The two flags fall together only after a second fixed delay has passed and the clock-ready acknowledge is high.

Host accesses pass through the block on their way to the register file and message RAM. While the low-power flag is set, the block refuses any access that falls in a protected region. The protected regions are the message RAM, the receive-buffer and receive-FIFO output registers, and the bank of 32 FIFO filter registers. A refused access is not forwarded, which means a refused write is lost. The block returns zero read data for it and raises an access-error pulse for one cycle. Accesses to any other address are forwarded in every state. The block produces clock-enable requests only and contains no clock gating cells.

Top module: `can_disable_seq`

## Requirements
- R1: After a synchronous reset the low-power flag `lp_status`, the not-ready flag `not_ready` and `acc_err` are 0, and both `pe_clk_en` and `hif_clk_en` are 1.
- R2: Take the clock edge that first samples `disable_req`=1 while running. Exactly OFF_DLY edges later (default 16), `lp_status` and `not_ready` become 1 and both clock enables become 0. Before that edge the outputs keep their running values.
- R3: If `disable_req` returns to 0 before the disable delay has expired, the disable is abandoned. The flags never rise and the clock enables stay 1.
- R4: In the disabled state, the first edge that samples `disable_req`=0 sets both clock enables to 1. `lp_status` and `not_ready` stay 1 at that edge.
- R5: `lp_status` and `not_ready` fall in the same cycle. They fall at the first edge that is at least ON_DLY edges (default 16) after the enable request and at which `clk_ready_ack` is 1. While `clk_ready_ack` is 0 they stay 1.
- R6: If `disable_req` returns to 1 while the sequencer waits for re-enable, both clock enables fall at the next edge and both flags stay 1.
- R7: The protected word addresses are 0x10 to 0x12 (receive-buffer and receive-FIFO output registers), 0x40 to 0x5F (FIFO filter bank) and 0x80 to 0xFF (message RAM). While `lp_status` is 1, an access strobe (`acc_valid`=1) to a protected address has these effects. `fwd_valid` stays 0 in that cycle. In the following cycle `acc_err` is 1 and `host_rdata` is 0. In the cycle after that, with no further strobe, `acc_err` is 0 again.
- R8: An access to an unprotected address is forwarded in every state. An access to any address is forwarded while `lp_status` is 0. Forwarded reads return the fabric's data on `host_rdata` one cycle after the strobe, and `acc_err` stays 0.
- R9: A write to a protected address made while `lp_status` is 1 leaves the target's contents unchanged, as seen by a later read after re-enable. A write to an unprotected address made in the same state takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disable_req | input | 1 | 1 requests the disabled state, 0 requests enable |
| clk_ready_ack | input | 1 | Both resumed clock domains are running |
| acc_valid | input | 1 | Host access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Host word address |
| acc_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data to the host, one cycle after the strobe |
| acc_err | output | 1 | One-cycle pulse after a refused access |
| fwd_valid | output | 1 | Strobe forwarded to the register file / RAM |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_wdata | output | DATA_W | Forwarded write data |
| fab_rdata | input | DATA_W | Read data from the register file / RAM, one cycle after `fwd_valid` |
| lp_status | output | 1 | Low-power status flag |
| not_ready | output | 1 | Not-ready flag |
| pe_clk_en | output | 1 | Clock-enable request for the protocol engine |
| hif_clk_en | output | 1 | Clock-enable request for the host interface |

## Verification
The bench counts edges around both delays and checks the exact edge at which the flags rise and fall. A design that is off by one in its counter would flip the flags one cycle early or late. The bench abandons a disable halfway, holds the acknowledge low past the enable delay, and re-requests disable during wake-up, which exposes a sequencer that ignores a request change in its waiting states. The bench then sweeps every one of the 256 addresses for reads while running and while disabled, and for writes while disabled, before reading everything back after re-enable. Those sweeps catch a window boundary decoded one word off, a refused write that still reaches the memory, and non-zero data returned on a refused read.

// File: rtl/can_dis_pkg.sv
package can_dis_pkg;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_ENTERING = 2'd1,
    ST_OFF      = 2'd2,
    ST_LEAVING  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/can_dis_timer.sv
// Saturating delay counter: counts while its owner state is active and
// reports done once LIMIT-1 has been reached.
module can_dis_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic done
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign done = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
    end
  end

  // the counter never runs beyond its terminal value (supports R2, R5)
  p_cnt_bounded_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

endmodule

// File: rtl/can_dis_fsm.sv
// Disable/enable sequencer with registered status and clock-enable outputs.
module can_dis_fsm
  import can_dis_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       disable_req,
  input  logic       clk_ready_ack,
  input  logic       off_done,
  input  logic       on_done,
  output seq_state_e state,
  output logic       lp_status,
  output logic       not_ready,
  output logic       pe_clk_en,
  output logic       hif_clk_en
);

  seq_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:      if (disable_req) nxt = ST_ENTERING;
      ST_ENTERING: if (!disable_req) nxt = ST_RUN;
                   else if (off_done) nxt = ST_OFF;
      ST_OFF:      if (!disable_req) nxt = ST_LEAVING;
      ST_LEAVING:  if (disable_req) nxt = ST_OFF;
                   else if (on_done && clk_ready_ack) nxt = ST_RUN;
      default:     nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_RUN;
      lp_status  <= 1'b0;
      not_ready  <= 1'b0;
      pe_clk_en  <= 1'b1;
      hif_clk_en <= 1'b1;
    end else begin
      state <= nxt;
      // flags: set on arrival in OFF, cleared together on return to RUN
      if (state == ST_ENTERING && nxt == ST_OFF) begin
        lp_status <= 1'b1;
        not_ready <= 1'b1;
      end else if (state == ST_LEAVING && nxt == ST_RUN) begin
        lp_status <= 1'b0;
        not_ready <= 1'b0;
      end
      // clock requests: dropped on entering OFF, restored on leaving it
      if (nxt == ST_OFF) begin
        pe_clk_en  <= 1'b0;
        hif_clk_en <= 1'b0;
      end else if (state == ST_OFF) begin
        pe_clk_en  <= 1'b1;
        hif_clk_en <= 1'b1;
      end
    end
  end

  p_rise_from_entering_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(lp_status) |-> $past(state) == ST_ENTERING);

  p_off_clocks_down_r2: assert property (@(posedge clk) disable iff (rst)
    state == ST_OFF |-> !pe_clk_en && !hif_clk_en);

  p_leaving_clocks_on_r4: assert property (@(posedge clk) disable iff (rst)
    state == ST_LEAVING |-> pe_clk_en && hif_clk_en && lp_status);

  p_fall_needs_ack_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(lp_status) |-> $past(clk_ready_ack) && $past(state) == ST_LEAVING);

  p_flags_together_r5: assert property (@(posedge clk) disable iff (rst)
    lp_status == not_ready);

  p_reenter_off_r6: assert property (@(posedge clk) disable iff (rst)
    state == ST_LEAVING && disable_req |=> state == ST_OFF);

endmodule

// File: rtl/can_dis_acc_guard.sv
// Host access filter: refuses protected windows while the block is disabled.
module can_dis_acc_guard #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned RXREG_BASE = 16,
  parameter int unsigned RXREG_CNT  = 3,
  parameter int unsigned FILT_BASE  = 64,
  parameter int unsigned FILT_CNT   = 32,
  parameter int unsigned RAM_BASE   = 128,
  parameter int unsigned RAM_WORDS  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blocked,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              acc_err,
  output logic              fwd_valid,
  output logic              fwd_write,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_wdata,
  input  logic [DATA_W-1:0] fab_rdata
);
  localparam int unsigned NWIN = 3;
  localparam int unsigned WBASE [NWIN] = '{RXREG_BASE, FILT_BASE, RAM_BASE};
  localparam int unsigned WCNT  [NWIN] = '{RXREG_CNT, FILT_CNT, RAM_WORDS};

  logic [NWIN-1:0] hit;
  logic            deny;
  logic            zero_q;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign hit[w] = (32'(acc_addr) >= WBASE[w]) &&
                    (32'(acc_addr) <  WBASE[w] + WCNT[w]);
  end

  assign deny      = acc_valid && blocked && (|hit);
  assign fwd_valid = acc_valid && !deny;
  assign fwd_write = acc_write;
  assign fwd_addr  = acc_addr;
  assign fwd_wdata = acc_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_err <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      acc_err <= deny;
      zero_q  <= deny;
    end
  end

  assign host_rdata = zero_q ? '0 : fab_rdata;

  p_err_after_blocked_r7: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> $past(acc_valid) && $past(blocked));

  p_err_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> host_rdata == '0);

  p_open_forward_r8: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !blocked |-> fwd_valid);

  p_running_no_err_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(blocked) |-> !acc_err);

endmodule

// File: rtl/can_disable_seq.sv
module can_disable_seq
  import can_dis_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned OFF_DLY    = 16,
  parameter int unsigned ON_DLY     = 16,
  parameter int unsigned RXREG_BASE = 16,
  parameter int unsigned RXREG_CNT  = 3,
  parameter int unsigned FILT_BASE  = 64,
  parameter int unsigned FILT_CNT   = 32,
  parameter int unsigned RAM_BASE   = 128,
  parameter int unsigned RAM_WORDS  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              disable_req,
  input  logic              clk_ready_ack,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              acc_err,
  output logic              fwd_valid,
  output logic              fwd_write,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_wdata,
  input  logic [DATA_W-1:0] fab_rdata,
  output logic              lp_status,
  output logic              not_ready,
  output logic              pe_clk_en,
  output logic              hif_clk_en
);

  seq_state_e state;
  logic       off_done;
  logic       on_done;

  can_dis_timer #(.LIMIT(OFF_DLY)) u_off_tmr (
    .clk  (clk),
    .rst  (rst),
    .clear(state != ST_ENTERING),
    .done (off_done)
  );

  can_dis_timer #(.LIMIT(ON_DLY)) u_on_tmr (
    .clk  (clk),
    .rst  (rst),
    .clear(state != ST_LEAVING),
    .done (on_done)
  );

  can_dis_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .disable_req  (disable_req),
    .clk_ready_ack(clk_ready_ack),
    .off_done     (off_done),
    .on_done      (on_done),
    .state        (state),
    .lp_status    (lp_status),
    .not_ready    (not_ready),
    .pe_clk_en    (pe_clk_en),
    .hif_clk_en   (hif_clk_en)
  );

  // protected windows stay closed for as long as the low-power flag is set
  can_dis_acc_guard #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .RXREG_BASE(RXREG_BASE),
    .RXREG_CNT (RXREG_CNT),
    .FILT_BASE (FILT_BASE),
    .FILT_CNT  (FILT_CNT),
    .RAM_BASE  (RAM_BASE),
    .RAM_WORDS (RAM_WORDS)
  ) u_guard (
    .clk       (clk),
    .rst       (rst),
    .blocked   (lp_status),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .host_rdata(host_rdata),
    .acc_err   (acc_err),
    .fwd_valid (fwd_valid),
    .fwd_write (fwd_write),
    .fwd_addr  (fwd_addr),
    .fwd_wdata (fwd_wdata),
    .fab_rdata (fab_rdata)
  );

endmodule

// File: tb/can_disable_seq_bench.sv
module can_disable_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int OFF_DLY = 16;
  localparam int ON_DLY = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic disable_req = 1'b0;
  logic clk_ready_ack = 1'b1;
  logic acc_valid = 1'b0;
  logic acc_write = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [DW-1:0] acc_wdata = '0;
  logic [DW-1:0] host_rdata, fwd_wdata, fab_rdata;
  logic acc_err, fwd_valid, fwd_write, lp_status, not_ready, pe_clk_en, hif_clk_en;
  logic [AW-1:0] fwd_addr;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] exp_mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  can_disable_seq u_can_disable_seq (
    .clk(clk), .rst(rst), .disable_req(disable_req), .clk_ready_ack(clk_ready_ack),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .host_rdata(host_rdata), .acc_err(acc_err),
    .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_addr(fwd_addr),
    .fwd_wdata(fwd_wdata), .fab_rdata(fab_rdata), .lp_status(lp_status),
    .not_ready(not_ready), .pe_clk_en(pe_clk_en), .hif_clk_en(hif_clk_en)
  );

  // register file / RAM model behind the guard
  always @(posedge clk) begin
    if (fwd_valid) begin
      if (fwd_write) mem[fwd_addr] <= fwd_wdata;
      else           fab_rdata <= mem[fwd_addr];
    end
  end

  function automatic bit is_prot(int a);
    return (a >= 128) || (a >= 64 && a < 96) || (a >= 16 && a <= 18);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_status(string req, bit lp, bit clk_on);
    chk(lp_status == lp && not_ready == lp, req, "flags",
        {lp_status, not_ready}, {lp, lp});
    chk(pe_clk_en == clk_on && hif_clk_en == clk_on, req, "clock enables",
        {pe_clk_en, hif_clk_en}, {clk_on, clk_on});
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // read at address a; check forwarding, error pulse and data
  task automatic do_read(int a, string req);
    bit prot = lp_status && is_prot(a);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = AW'(a);
    #1;
    chk(fwd_valid == !prot, req, "fwd_valid on read", fwd_valid, !prot);
    step();
    acc_valid = 1'b0;
    chk(acc_err == prot, req, "acc_err after read", acc_err, prot);
    chk(host_rdata == (prot ? '0 : exp_mem[a]), req, "read data",
        host_rdata, prot ? '0 : exp_mem[a]);
    step();
    chk(acc_err == 1'b0, req, "acc_err pulse ends", acc_err, 0);
  endtask

  task automatic do_write(int a, logic [DW-1:0] d, string req);
    bit prot = lp_status && is_prot(a);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = AW'(a); acc_wdata = d;
    #1;
    chk(fwd_valid == !prot, req, "fwd_valid on write", fwd_valid, !prot);
    if (!prot) exp_mem[a] = d;
    step();
    acc_valid = 1'b0;
    chk(acc_err == prot, req, "acc_err after write", acc_err, prot);
    step();
  endtask

  // drive disable_req=1 from RUN, watch the exact rise edge
  task automatic go_off();
    disable_req = 1'b1;
    for (int i = 1; i <= OFF_DLY + 1; i++) begin
      step();
      chk_status("R2", i == OFF_DLY + 1, i != OFF_DLY + 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    for (int a = 0; a < 256; a++) begin
      mem[a] = DW'(a * 7 + 5);
      exp_mem[a] = DW'(a * 7 + 5);
    end
    repeat (3) step();
    chk_status("R1", 1'b0, 1'b1);
    chk(acc_err == 1'b0, "R1", "acc_err in reset", acc_err, 0);
    rst = 1'b0;
    step();
    chk_status("R1", 1'b0, 1'b1);

    // R8: every address open while running
    for (int a = 0; a < 256; a++) do_read(a, "R8");

    // R3: abandoned disable
    disable_req = 1'b1;
    repeat (OFF_DLY / 2) step();
    disable_req = 1'b0;
    for (int i = 0; i < OFF_DLY + 4; i++) begin
      step();
      chk_status("R3", 1'b0, 1'b1);
    end

    go_off();

    // R7/R8: read sweep while disabled
    for (int a = 0; a < 256; a++) do_read(a, "R7");

    // R9: write sweep while disabled
    for (int a = 0; a < 256; a++) do_write(a, DW'(32'hA500_0000 | a), "R9");

    // R4/R5: enable with acknowledge low, then raise it late
    clk_ready_ack = 1'b0;
    disable_req = 1'b0;
    step();
    chk_status("R4", 1'b1, 1'b1);
    for (int i = 2; i <= ON_DLY + 4; i++) begin
      step();
      chk_status("R5", 1'b1, 1'b1);
    end
    clk_ready_ack = 1'b1;
    step();
    chk_status("R5", 1'b0, 1'b1);

    // R9: read back everything now that the block is running
    for (int a = 0; a < 256; a++) do_read(a, "R9");

    // R6: disable again, re-request during wake-up
    go_off();
    disable_req = 1'b0;
    step();
    chk_status("R4", 1'b1, 1'b1);
    repeat (3) step();
    disable_req = 1'b1;
    step();
    chk_status("R6", 1'b1, 1'b0);
    step();
    chk_status("R6", 1'b1, 1'b0);

    // R5: acknowledge held high, exact fall edge
    disable_req = 1'b0;
    for (int i = 1; i <= ON_DLY + 1; i++) begin
      step();
      chk_status("R5", i != ON_DLY + 1, 1'b1);
    end

    finish_run();
  end
endmodule